// File: doc/BRIEF.md
# DRAM strobe cycle decoder

This block is the control front end of a model of a multiplexed-address DRAM device. It samples the active-low row strobe, column strobe and write enable, together with a 10-bit shared address bus, on a system clock. From the order in which the strobes fall, it works out what kind of cycle each row-strobe-low period is. The possible kinds are an ordinary access (read, early write, read-modify-write, page mode), a refresh of an externally addressed row, a refresh of an internally counted row with the column strobe leading, a hidden refresh that follows a read, self-refresh, and test-mode entry.

The block latches the row half and the column half of the 20-bit word address. It owns the internal refresh row counter and the test-mode flag. It also raises a one-clock write-capture pulse on whichever of the column-strobe fall and the write-enable fall comes later. The storage array and the data pins sit downstream and use these outputs. All strobe inputs are treated as synchronous to `clk`. Every output changes on the clock edge that first samples the strobe edge that causes the change.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After a synchronous active-low reset, `cyc_type` reads 0 (idle), and `row_addr`, `col_addr` and `refresh_row` read 0. `test_mode`, `self_refresh` and `wr_strobe` read 0.
- R2: A row-strobe fall sampled while the column strobe is high latches `addr` into `row_addr` and sets `cyc_type` to 1 (active).
- R3: A column-strobe fall during an active, read or write cycle latches `addr` into `col_addr`. If write enable is high, `cyc_type` becomes 2 (read) and `wr_strobe` stays 0. If write enable is already low (early write), `cyc_type` becomes 3 (write) and `wr_strobe` pulses for one clock on that edge.
- R4: A write-enable fall while both strobes are low in a read cycle turns `cyc_type` into 3 and pulses `wr_strobe` for one clock on that later edge.
- R5: A row-strobe high-low-high period with no column-strobe fall sets `cyc_type` to 4 (row-only refresh) on the rising edge. It keeps the external row in `row_addr`, leaves `refresh_row` unchanged and clears `test_mode`.
- R6: A row-strobe fall while the column strobe is already low and write enable is high sets `cyc_type` to 5 (counted refresh). It loads `row_addr` with the counter value, ignores `addr`, and advances `refresh_row` by one. Repeated row-strobe cycles with the column strobe held low each do the same.
- R7: When the column strobe stays low after a read cycle and the row strobe then cycles, `cyc_type` becomes 6 (hidden refresh). `row_addr` takes the counter value, `col_addr` keeps the read column, and `refresh_row` advances by one.
- R8: A counted refresh with write enable low sets `cyc_type` to 8 (test entry), sets `test_mode` and advances the counter. `test_mode` stays set through ordinary accesses and is cleared by a row-only refresh or a counted refresh.
- R9: When both strobes stay low for `SELF_TH` clocks after the row-strobe fall of a counted refresh, `self_refresh` rises and `cyc_type` becomes 7. One clock earlier, `self_refresh` is still 0.
- R10: While `self_refresh` is set, `refresh_row` advances by one every `OSC_DIV` clocks, the first step coming `OSC_DIV` clocks after entry.
- R11: Self-refresh ends only on the edge that samples both strobes high, after which `cyc_type` reads 0. The row strobe rising alone does not end it.
- R12: `refresh_row` is `ADDR_W` bits wide and wraps to its start value after 2^`ADDR_W` steps.
- R13: In page mode, each column-strobe fall within one row-strobe-low period latches a new `col_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_type | output | 4 | Cycle classification code (see requirements) |
| row_addr | output | ADDR_W | Latched row, or refreshed internal row |
| col_addr | output | ADDR_W | Latched column |
| refresh_row | output | ADDR_W | Next internal refresh row |
| test_mode | output | 1 | Test mode flag |
| self_refresh | output | 1 | Self-refresh active |
| wr_strobe | output | 1 | One-clock pulse at the write data capture point |

## Verification
The hardest state to reach from the ports is self-refresh. Getting there takes a counted refresh whose strobes then stay low for an exact number of clocks. Leaving it needs both strobes high together, while the internal oscillator keeps moving the counter in the background. The stimulus holds both strobes low and checks the flag one clock before and at the threshold. It then counts clocks from entry to predict each oscillator step. It raises the row strobe alone at a point where no step is due, to show that self-refresh holds, and finally releases the column strobe to exit. The hidden refresh is reached by ending a read with only the row strobe rising, so the column strobe stays low across the next row-strobe fall.

// File: rtl/dsd_pkg.sv
// Shared types for the DRAM strobe cycle decoder.
package dsd_pkg;
    typedef enum logic [3:0] {
        CYC_IDLE       = 4'd0,
        CYC_ACTIVE     = 4'd1,
        CYC_READ       = 4'd2,
        CYC_WRITE      = 4'd3,
        CYC_RAS_ONLY   = 4'd4,
        CYC_CBR        = 4'd5,
        CYC_HIDDEN     = 4'd6,
        CYC_SELF       = 4'd7,
        CYC_TEST_ENTRY = 4'd8
    } cyc_e;
endpackage

// File: rtl/dsd_edge.sv
// Edge detector for a group of active-low strobes.
// Keeps the previous sample of each strobe and reports falling and rising
// edges as one-clock pulses. Assumes the inputs are already synchronous.
// After reset the previous samples read "inactive" (high).
module dsd_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember the last sample of strobe i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= strobe_n[i];
        end
        assign fall[i] = prev_n[i] & ~strobe_n[i];
        assign rise[i] = ~prev_n[i] & strobe_n[i];
    end
endmodule

// File: rtl/dsd_refresh_ctr.sv
// Internal refresh row counter.
// Advances by one on each increment request and wraps after 2**ROW_W rows.
// Assumes the callers never request two increments in the same clock.
module dsd_refresh_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    // Count refreshed rows.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> row == $past(row) + 1'b1);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row));
endmodule

// File: rtl/dsd_self_timer.sv
// Self-refresh timer and internal oscillator.
// Armed by the row-strobe fall of a counted refresh. It counts the clocks
// during which both strobes stay low and enters self-refresh after SELF_TH
// of them. While in self-refresh it emits a tick every OSC_DIV clocks. It
// leaves self-refresh on the edge that samples both strobes high.
// Assumes SELF_TH >= 2 and OSC_DIV >= 2.
module dsd_self_timer #(
    parameter int SELF_TH = 64,
    parameter int OSC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ras_n,
    input  logic cas_n,
    output logic enter,
    output logic leave,
    output logic active,
    output logic tick
);
    localparam int CW = $clog2(SELF_TH);
    localparam int DW = $clog2(OSC_DIV);

    logic          armed;
    logic [CW-1:0] hold_cnt;
    logic [DW-1:0] div_cnt;
    logic          both_low;

    assign both_low = !ras_n && !cas_n;
    assign enter    = armed && !active && both_low && (hold_cnt == CW'(SELF_TH - 1));
    assign leave    = active && ras_n && cas_n;
    assign tick     = active && !leave && (div_cnt == DW'(OSC_DIV - 1));

    // Measure how long both strobes stay low after a counted refresh starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            hold_cnt <= '0;
        end else if (arm) begin
            armed    <= 1'b1;
            hold_cnt <= '0;
        end else if (armed && (!both_low || enter)) begin
            armed    <= 1'b0;
        end else if (armed) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Track the self-refresh state.
    always_ff @(posedge clk) begin
        if (!rst_n)     active <= 1'b0;
        else if (enter) active <= 1'b1;
        else if (leave) active <= 1'b0;
    end

    // Divide the clock down to the internal refresh oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n || enter || !active || tick) div_cnt <= '0;
        else                                    div_cnt <= div_cnt + 1'b1;
    end

    assert_stay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (!ras_n || !cas_n)) |=> active);
    assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dsd_classifier.sv
// Strobe-order classifier.
// Decides the kind of each row-strobe-low period from the order of strobe
// edges. It latches the row and column addresses, holds the test-mode flag
// and produces the write-capture pulse. It requests refresh counter steps
// and arms the self-refresh timer. Strobe index 0 is the row strobe,
// 1 the column strobe and 2 write enable. Edge pulses come from dsd_edge.
module dsd_classifier
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fall,
    input  logic [2:0]        rise,
    input  logic              self_active,
    input  logic              self_enter,
    input  logic              self_leave,
    input  logic [ADDR_W-1:0] refresh_row,
    output cyc_e              cyc_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              test_mode,
    output logic              wr_strobe,
    output logic              refresh_go,
    output logic              cbr_go
);
    logic ras_fall, cas_fall, we_fall, ras_rise;
    logic refresh_start, hidden_go, test_go, open_go;
    logic in_access, col_go, wlate_go, ror_go;
    logic read_hold;
    logic unused_ok;

    assign ras_fall  = fall[0];
    assign cas_fall  = fall[1];
    assign we_fall   = fall[2];
    assign ras_rise  = rise[0];
    assign unused_ok = ^rise[2:1];

    assign refresh_start = ras_fall && !cas_n && !self_active;
    assign hidden_go     = refresh_start && read_hold;
    assign test_go       = refresh_start && !read_hold && !we_n;
    assign cbr_go        = refresh_start && !read_hold && we_n;
    assign refresh_go    = refresh_start;
    assign open_go       = ras_fall && cas_n && !self_active;

    assign in_access = !ras_n && !ras_fall &&
                       (cyc_type inside {CYC_ACTIVE, CYC_READ, CYC_WRITE});
    assign col_go    = cas_fall && in_access;
    assign wlate_go  = we_fall && !cas_n && !cas_fall && in_access &&
                       (cyc_type == CYC_READ);
    assign ror_go    = ras_rise && (cyc_type == CYC_ACTIVE);

    // Classify the cycle and latch addresses, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_type  <= CYC_IDLE;
            row_addr  <= '0;
            col_addr  <= '0;
            test_mode <= 1'b0;
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            if (self_enter) begin
                cyc_type <= CYC_SELF;
            end else if (self_leave) begin
                cyc_type <= CYC_IDLE;
            end else if (hidden_go) begin
                cyc_type  <= CYC_HIDDEN;
                row_addr  <= refresh_row;
                test_mode <= 1'b0;
            end else if (test_go) begin
                cyc_type  <= CYC_TEST_ENTRY;
                row_addr  <= refresh_row;
                test_mode <= 1'b1;
            end else if (cbr_go) begin
                cyc_type  <= CYC_CBR;
                row_addr  <= refresh_row;
                test_mode <= 1'b0;
            end else if (open_go) begin
                cyc_type <= CYC_ACTIVE;
                row_addr <= addr;
            end else if (col_go) begin
                col_addr  <= addr;
                cyc_type  <= we_n ? CYC_READ : CYC_WRITE;
                wr_strobe <= !we_n;
            end else if (wlate_go) begin
                cyc_type  <= CYC_WRITE;
                wr_strobe <= 1'b1;
            end else if (ror_go) begin
                cyc_type  <= CYC_RAS_ONLY;
                test_mode <= 1'b0;
            end
        end
    end

    // Remember a read whose column strobe is still held low after row close.
    always_ff @(posedge clk) begin
        if (!rst_n || cas_n)                        read_hold <= 1'b0;
        else if (ras_rise && cyc_type == CYC_READ)  read_hold <= 1'b1;
    end

    assert_wr_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> cyc_type == CYC_WRITE);
    assert_notest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_CBR || cyc_type == CYC_RAS_ONLY) |-> !test_mode);
    assert_col_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hidden_go |=> $stable(col_addr));
endmodule

// File: rtl/dram_strobe_decoder.sv
// DRAM strobe cycle decoder, top level.
// Wires the edge detector, the classifier, the self-refresh timer and the
// refresh row counter together. All inputs are assumed synchronous to clk.
// The refresh counter is as wide as the address bus.
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int SELF_TH = 64,
    parameter int OSC_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cyc_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [ADDR_W-1:0] refresh_row,
    output logic              test_mode,
    output logic              self_refresh,
    output logic              wr_strobe
);
    logic [2:0] fall, rise;
    logic       self_enter, self_leave, osc_tick;
    logic       refresh_go, cbr_go;
    cyc_e       cyc_q;

    dsd_edge #(.N(3)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({we_n, cas_n, ras_n}),
        .fall     (fall),
        .rise     (rise)
    );

    dsd_classifier #(.ADDR_W(ADDR_W)) u_cls (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .addr        (addr),
        .fall        (fall),
        .rise        (rise),
        .self_active (self_refresh),
        .self_enter  (self_enter),
        .self_leave  (self_leave),
        .refresh_row (refresh_row),
        .cyc_type    (cyc_q),
        .row_addr    (row_addr),
        .col_addr    (col_addr),
        .test_mode   (test_mode),
        .wr_strobe   (wr_strobe),
        .refresh_go  (refresh_go),
        .cbr_go      (cbr_go)
    );

    dsd_self_timer #(.SELF_TH(SELF_TH), .OSC_DIV(OSC_DIV)) u_self (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (cbr_go),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .enter  (self_enter),
        .leave  (self_leave),
        .active (self_refresh),
        .tick   (osc_tick)
    );

    dsd_refresh_ctr #(.ROW_W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (refresh_go | osc_tick),
        .row   (refresh_row)
    );

    assign cyc_type = cyc_q;

    assert_self_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_refresh) |-> cyc_type == 4'd7);
endmodule

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int SELF_TH    = 64;
    localparam int OSC_DIV    = 8;
    localparam int ROWS       = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    cyc_type;
    logic [AW-1:0] row_addr, col_addr, refresh_row;
    logic          test_mode, self_refresh, wr_strobe;

    int total = 0;
    int bad   = 0;
    int exp_row = 0;

    dram_strobe_decoder #(.ADDR_W(AW), .SELF_TH(SELF_TH), .OSC_DIV(OSC_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .cyc_type(cyc_type), .row_addr(row_addr), .col_addr(col_addr),
        .refresh_row(refresh_row), .test_mode(test_mode),
        .self_refresh(self_refresh), .wr_strobe(wr_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic close_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        step(); step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 type", cyc_type, 0);
        chk("R1 row", row_addr, 0);
        chk("R1 col", col_addr, 0);
        chk("R1 refresh", refresh_row, 0);
        chk("R1 test", test_mode, 0);
        chk("R1 self", self_refresh, 0);
        chk("R1 wr", wr_strobe, 0);
    endtask

    task automatic t_read();
        addr = 10'h155; ras_n = 1'b0; step();
        chk("R2 type", cyc_type, 1);
        chk("R2 row", row_addr, 'h155);
        addr = 10'h0AA; cas_n = 1'b0; step();
        chk("R3 read type", cyc_type, 2);
        chk("R3 read col", col_addr, 'h0AA);
        chk("R3 read wr", wr_strobe, 0);
        close_all();
    endtask

    task automatic t_early_write();
        addr = 10'h201; ras_n = 1'b0; step();
        we_n = 1'b0; addr = 10'h3FF; cas_n = 1'b0; step();
        chk("R3 write type", cyc_type, 3);
        chk("R3 write col", col_addr, 'h3FF);
        chk("R3 write pulse", wr_strobe, 1);
        step();
        chk("R3 pulse width", wr_strobe, 0);
        close_all();
    endtask

    task automatic t_rmw();
        addr = 10'h011; ras_n = 1'b0; step();
        addr = 10'h022; cas_n = 1'b0; step();
        chk("R4 read first", cyc_type, 2);
        chk("R4 no pulse yet", wr_strobe, 0);
        we_n = 1'b0; step();
        chk("R4 late write type", cyc_type, 3);
        chk("R4 late pulse", wr_strobe, 1);
        step();
        chk("R4 pulse width", wr_strobe, 0);
        close_all();
    endtask

    task automatic t_page();
        addr = 10'h0F0; ras_n = 1'b0; step();
        for (int i = 0; i < 3; i++) begin
            addr = AW'(10'h100 + i * 7); cas_n = 1'b0; step();
            chk("R13 page col", col_addr, 'h100 + i * 7);
            cas_n = 1'b1; step();
        end
        chk("R13 row kept", row_addr, 'h0F0);
        close_all();
    endtask

    task automatic t_cbr();
        addr = 10'h3A5; cas_n = 1'b0; step();
        ras_n = 1'b0; step();
        chk("R6 type", cyc_type, 5);
        chk("R6 row from counter", row_addr, exp_row);
        exp_row = (exp_row + 1) % ROWS;
        chk("R6 counter step", refresh_row, exp_row);
        ras_n = 1'b1; step();
        ras_n = 1'b0; step();
        chk("R6 repeated type", cyc_type, 5);
        chk("R6 repeated row", row_addr, exp_row);
        exp_row = (exp_row + 1) % ROWS;
        chk("R6 repeated counter", refresh_row, exp_row);
        chk("R6 test cleared", test_mode, 0);
        close_all();
    endtask

    task automatic t_hidden();
        addr = 10'h066; ras_n = 1'b0; step();
        addr = 10'h077; cas_n = 1'b0; step();
        ras_n = 1'b1; step();
        addr = 10'h2C3; ras_n = 1'b0; step();
        chk("R7 type", cyc_type, 6);
        chk("R7 row from counter", row_addr, exp_row);
        chk("R7 col kept", col_addr, 'h077);
        exp_row = (exp_row + 1) % ROWS;
        chk("R7 counter step", refresh_row, exp_row);
        close_all();
    endtask

    task automatic t_test_mode();
        cas_n = 1'b0; step();
        we_n = 1'b0; ras_n = 1'b0; step();
        chk("R8 entry type", cyc_type, 8);
        chk("R8 flag set", test_mode, 1);
        exp_row = (exp_row + 1) % ROWS;
        chk("R8 counter step", refresh_row, exp_row);
        close_all();
        addr = 10'h123; ras_n = 1'b0; step();
        cas_n = 1'b0; step();
        close_all();
        chk("R8 kept through read", test_mode, 1);
        addr = 10'h2EE; ras_n = 1'b0; step(); step();
        ras_n = 1'b1; step();
        chk("R5 type", cyc_type, 4);
        chk("R5 row external", row_addr, 'h2EE);
        chk("R5 counter kept", refresh_row, exp_row);
        chk("R5 R8 test cleared", test_mode, 0);
        close_all();
        cas_n = 1'b0; step();
        we_n = 1'b0; ras_n = 1'b0; step();
        exp_row = (exp_row + 1) % ROWS;
        chk("R8 entry again", test_mode, 1);
        close_all();
        t_cbr();
        chk("R8 cleared by counted refresh", test_mode, 0);
    endtask

    task automatic t_self();
        cas_n = 1'b0; step();
        ras_n = 1'b0; step();
        exp_row = (exp_row + 1) % ROWS;
        chk("R9 starts as counted", cyc_type, 5);
        repeat (SELF_TH - 1) step();
        chk("R9 not yet", self_refresh, 0);
        step();
        chk("R9 entered", self_refresh, 1);
        chk("R9 type", cyc_type, 7);
        repeat (OSC_DIV - 1) step();
        chk("R10 before tick", refresh_row, exp_row);
        step();
        exp_row = (exp_row + 1) % ROWS;
        chk("R10 first tick", refresh_row, exp_row);
        ras_n = 1'b1; step(); step();
        chk("R11 row strobe alone", self_refresh, 1);
        chk("R11 type kept", cyc_type, 7);
        cas_n = 1'b1; step();
        chk("R11 exited", self_refresh, 0);
        chk("R11 idle type", cyc_type, 0);
        chk("R11 counter", refresh_row, exp_row);
        close_all();
    endtask

    task automatic t_wrap();
        int start;
        start = exp_row;
        cas_n = 1'b0; step();
        for (int i = 0; i < ROWS; i++) begin
            ras_n = 1'b0; step();
            ras_n = 1'b1; step();
            if (i == ROWS - 2)
                chk("R12 one short", refresh_row, (start + ROWS - 1) % ROWS);
        end
        chk("R12 wrapped", refresh_row, start);
        close_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_read();
        t_early_write();
        t_rmw();
        t_page();
        t_cbr();
        t_hidden();
        t_test_mode();
        t_self();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule